// File: doc/BRIEF.md
# I2C Frame Guard with Stuck-Clock Timeout

This block watches the byte stream of a node's two-wire serial receiver and adds two protections that the plain bus does not have. The first is a framing check. A received message carries an address byte, a byte count, that many payload bytes and a 16-bit CRC. A critical hardware command is a payload byte with its top bit set, and it must be followed at once by its bitwise complement. The block flags each closed frame as good, CRC-bad, wrong length or complement-bad. For a good critical frame it also presents the command byte.

The second protection is a clock-low timer. A faulty node that holds SCL low would stall every sender without limit. The timer counts the cycles for which the sampled SCL level stays low and restarts whenever SCL is seen high. Once the count reaches a programmable limit, the block raises a sticky driver-disable that turns off the node's SDA and SCL transmitters. Receive decoding carries on while the drivers are off. A received re-enable command lifts the disable. Bit-level signalling and arbitration happen upstream of this block.

Top module: `i2c_frame_guard`

## Requirements
- R1: After reset, frame_valid_o, crc_err_o, len_err_o, cmp_err_o, cmd_valid_o and drv_dis_o are all low.
- R2: A frame is start_i, then bytes in this order: address, count N, N payload bytes, CRC high byte, CRC low byte, then stop_i. The CRC is CRC-16 with polynomial 0x1021 and initial value 0xFFFF, processed MSB first with no final XOR, over the address, count and payload bytes. When the frame has the right length, a matching CRC, and is not critical or passes R5, frame_valid_o pulses for one cycle in the cycle after the stop_i sample. N = 0 is a legal frame.
- R3: A frame of the right length whose received CRC differs from the computed CRC gives a one-cycle crc_err_o pulse and no frame_valid_o.
- R4: A stop_i after fewer or more than N+4 bytes gives a one-cycle len_err_o pulse. That frame raises no other flag and no command.
- R5: A frame is critical when N >= 1 and bit 7 of payload byte 0 is 1. A critical frame of the right length with a matching CRC raises cmp_err_o, and no frame_valid_o, unless N >= 2 and payload byte 1 equals the bitwise inverse of payload byte 0.
- R6: A valid critical frame pulses cmd_valid_o together with frame_valid_o, with cmd_o equal to payload byte 0. A valid non-critical frame gives no cmd_valid_o.
- R7: Bytes and stop_i outside a start..stop window raise nothing. A start_i inside a frame discards the bytes received so far and begins a new frame.
- R8: drv_dis_o rises in the cycle after scl_i has been sampled low on tmo_limit_i consecutive clock edges. Any high sample restarts the count.
- R9: drv_dis_o stays high until a valid re-enable command frame, payload 0xA5 then 0x5A, arrives. It falls in the cycle after that frame's cmd_valid_o pulse. Other commands leave it set. Frames are still decoded while it is set.
- R10: If the timer expires in the same cycle as a re-enable cmd_valid_o pulse, drv_dis_o stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start condition seen (one cycle) |
| stop_i | input | 1 | Stop condition seen (one cycle) |
| byte_valid_i | input | 1 | byte_i holds a received byte |
| byte_i | input | 8 | Received byte |
| scl_i | input | 1 | Sampled SCL level |
| tmo_limit_i | input | TMO_W | Clock-low limit in cycles |
| frame_valid_o | output | 1 | Good frame pulse |
| crc_err_o | output | 1 | CRC mismatch pulse |
| len_err_o | output | 1 | Length error pulse |
| cmp_err_o | output | 1 | Command complement error pulse |
| cmd_valid_o | output | 1 | Critical command accepted |
| cmd_o | output | 8 | Accepted command byte |
| drv_dis_o | output | 1 | SDA/SCL transmitter disable |

## Verification
The clock-low timer and the command path can both act on drv_dis_o in the same cycle: an expiry sets it and a re-enable clears it. The bench provokes this by holding scl_i low across a whole re-enable frame, so the timer is still expired when the command pulse arrives. It then expects the disable to stay high, while the same frame with scl_i high clears it. A behavioural model computes every output each cycle, including the one-cycle delay between the command pulse and the release.

// File: rtl/fg_pkg.sv
package fg_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam logic [15:0] CRC_POLY = 16'h1021;
  localparam logic [15:0] CRC_INIT = 16'hFFFF;

  function automatic logic [15:0] crc16_upd(input logic [15:0] crc, input logic [BYTE_W-1:0] b);
    logic [15:0] c;
    c = crc ^ {b, 8'h00};
    for (int i = 0; i < BYTE_W; i++)
      c = c[15] ? ((c << 1) ^ CRC_POLY) : (c << 1);
    return c;
  endfunction
endpackage

// File: rtl/fg_frame_check.sv
module fg_frame_check
  import fg_pkg::*;
#(
  parameter int unsigned IDX_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              byte_valid_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              frame_valid_o,
  output logic              crc_err_o,
  output logic              len_err_o,
  output logic              cmp_err_o,
  output logic              cmd_valid_o,
  output logic [BYTE_W-1:0] cmd_o
);
  localparam logic [IDX_W-1:0] IDX_MAX = '1;

  logic              active_q;
  logic [IDX_W-1:0]  idx_q;
  logic [BYTE_W-1:0] cnt_q, d0_q, d1_q;
  logic [15:0]       crc_q, rx_q;

  logic [IDX_W-1:0] cnt_ext;
  logic in_body, len_ok, crc_ok, crit, cmp_ok;

  assign cnt_ext = IDX_W'(cnt_q);
  // address and count always covered; payload while idx < count+2
  assign in_body = (idx_q < IDX_W'(2)) || (idx_q < cnt_ext + IDX_W'(2));
  assign len_ok  = (idx_q >= IDX_W'(2)) && (idx_q == cnt_ext + IDX_W'(4));
  assign crc_ok  = (rx_q == crc_q);
  assign crit    = (cnt_q != '0) && d0_q[BYTE_W-1];
  assign cmp_ok  = (cnt_q >= BYTE_W'(2)) && (d1_q == ~d0_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q      <= 1'b0;
      idx_q         <= '0;
      cnt_q         <= '0;
      d0_q          <= '0;
      d1_q          <= '0;
      crc_q         <= CRC_INIT;
      rx_q          <= '0;
      frame_valid_o <= 1'b0;
      crc_err_o     <= 1'b0;
      len_err_o     <= 1'b0;
      cmp_err_o     <= 1'b0;
      cmd_valid_o   <= 1'b0;
      cmd_o         <= '0;
    end else begin
      frame_valid_o <= 1'b0;
      crc_err_o     <= 1'b0;
      len_err_o     <= 1'b0;
      cmp_err_o     <= 1'b0;
      cmd_valid_o   <= 1'b0;
      if (start_i) begin
        active_q <= 1'b1;
        idx_q    <= '0;
        cnt_q    <= '0;
        d0_q     <= '0;
        d1_q     <= '0;
        crc_q    <= CRC_INIT;
      end else if (stop_i) begin
        active_q <= 1'b0;
        if (active_q) begin
          if (!len_ok)           len_err_o <= 1'b1;
          else if (!crc_ok)      crc_err_o <= 1'b1;
          else if (crit && !cmp_ok) cmp_err_o <= 1'b1;
          else begin
            frame_valid_o <= 1'b1;
            if (crit) begin
              cmd_valid_o <= 1'b1;
              cmd_o       <= d0_q;
            end
          end
        end
      end else if (byte_valid_i && active_q) begin
        if (idx_q != IDX_MAX)    idx_q <= idx_q + IDX_W'(1);
        if (idx_q == IDX_W'(1))  cnt_q <= byte_i;
        if (idx_q == IDX_W'(2))  d0_q  <= byte_i;
        if (idx_q == IDX_W'(3))  d1_q  <= byte_i;
        if (in_body)             crc_q <= crc16_upd(crc_q, byte_i);
        rx_q <= {rx_q[7:0], byte_i};
      end
    end
  end

  // R2
  flags_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({frame_valid_o, crc_err_o, len_err_o, cmp_err_o}));
  // R4
  len_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    len_err_o |-> !cmd_valid_o && !frame_valid_o);
  // R6
  cmd_needs_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> frame_valid_o);
  // R7
  flag_after_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_valid_o || crc_err_o || len_err_o || cmp_err_o) |-> $past(stop_i));
endmodule

// File: rtl/fg_scl_timer.sv
module fg_scl_timer #(
  parameter int unsigned TMO_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_i,
  input  logic [TMO_W-1:0] limit_i,
  output logic             expire_o
);
  localparam logic [TMO_W-1:0] CNT_MAX = '1;

  logic [TMO_W-1:0] cnt_q;
  logic [TMO_W:0]   nxt;

  assign nxt      = {1'b0, cnt_q} + (TMO_W+1)'(1);
  assign expire_o = !scl_i && (nxt >= {1'b0, limit_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (scl_i)            cnt_q <= '0;
    else if (cnt_q != CNT_MAX) cnt_q <= nxt[TMO_W-1:0];
  end

  // R8
  restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scl_i |=> !expire_o || (limit_i <= TMO_W'(1)));
endmodule

// File: rtl/i2c_frame_guard.sv
module i2c_frame_guard
  import fg_pkg::*;
#(
  parameter int unsigned TMO_W   = 24,
  parameter int unsigned IDX_W   = 10,
  parameter logic [7:0]  REEN_OP = 8'hA5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             byte_valid_i,
  input  logic [7:0]       byte_i,
  input  logic             scl_i,
  input  logic [TMO_W-1:0] tmo_limit_i,
  output logic             frame_valid_o,
  output logic             crc_err_o,
  output logic             len_err_o,
  output logic             cmp_err_o,
  output logic             cmd_valid_o,
  output logic [7:0]       cmd_o,
  output logic             drv_dis_o
);
  logic tmr_exp, reen;

  fg_frame_check #(.IDX_W(IDX_W)) u_frame (
    .clk_i, .rst_ni, .start_i, .stop_i, .byte_valid_i, .byte_i,
    .frame_valid_o, .crc_err_o, .len_err_o, .cmp_err_o, .cmd_valid_o, .cmd_o
  );

  fg_scl_timer #(.TMO_W(TMO_W)) u_timer (
    .clk_i, .rst_ni, .scl_i, .limit_i(tmo_limit_i), .expire_o(tmr_exp)
  );

  assign reen = cmd_valid_o && (cmd_o == REEN_OP);

  // expiry has priority over re-enable
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      drv_dis_o <= 1'b0;
    else if (tmr_exp) drv_dis_o <= 1'b1;
    else if (reen)    drv_dis_o <= 1'b0;
  end

  // R8
  exp_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_exp |=> drv_dis_o);
  // R9
  dis_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drv_dis_o && !reen |=> drv_dis_o);
  // R10
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_exp && reen |=> drv_dis_o);
endmodule

// File: tb/i2c_frame_guard_bench.sv
module i2c_frame_guard_bench;
  localparam int TMO_W = 24;
  localparam int LIMIT = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0, stop_i = 1'b0, byte_valid_i = 1'b0, scl_i = 1'b1;
  logic [7:0] byte_i = 8'h00;
  logic [TMO_W-1:0] tmo_limit_i = TMO_W'(LIMIT);
  logic frame_valid_o, crc_err_o, len_err_o, cmp_err_o, cmd_valid_o, drv_dis_o;
  logic [7:0] cmd_o;

  always #2 clk = ~clk;

  i2c_frame_guard #(.TMO_W(TMO_W)) u_i2c_frame_guard (
    .clk_i(clk), .rst_ni, .start_i, .stop_i, .byte_valid_i, .byte_i, .scl_i,
    .tmo_limit_i, .frame_valid_o, .crc_err_o, .len_err_o, .cmp_err_o,
    .cmd_valid_o, .cmd_o, .drv_dis_o
  );

  int n_chk = 0, n_fail = 0;
  int seen_fv = 0, seen_crc = 0, seen_len = 0, seen_cmp = 0, seen_cmd = 0;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // reference model
  function automatic logic [15:0] ref_crc(ref logic [7:0] d[$], input int n);
    logic [15:0] c = 16'hFFFF;
    for (int k = 0; k < n; k++)
      for (int j = 7; j >= 0; j--) begin
        logic fb;
        fb = c[15] ^ d[k][j];
        c = {c[14:0], 1'b0};
        if (fb) c = c ^ 16'h1021;
      end
    return c;
  endfunction

  logic [7:0] q[$];
  bit m_act = 0, m_dis = 0;
  bit e_fv = 0, e_crc = 0, e_len = 0, e_cmp = 0, e_cmdv = 0;
  logic [7:0] e_cmd = 0;
  int low_cnt = 0;

  always @(posedge clk) begin
    if (!rst_ni) begin
      q.delete(); m_act = 0; m_dis = 0; low_cnt = 0;
      e_fv = 0; e_crc = 0; e_len = 0; e_cmp = 0; e_cmdv = 0;
    end else begin
      bit exp_now, reen_now;
      reen_now = e_cmdv && (e_cmd == 8'hA5);
      if (scl_i) low_cnt = 0; else low_cnt++;
      exp_now = !scl_i && (low_cnt >= int'(tmo_limit_i));
      if (exp_now) m_dis = 1; else if (reen_now) m_dis = 0;
      e_fv = 0; e_crc = 0; e_len = 0; e_cmp = 0; e_cmdv = 0;
      if (start_i) begin
        m_act = 1; q.delete();
      end else if (stop_i) begin
        if (m_act) begin
          int n;
          n = q.size();
          if (n < 2 || n != int'(q[1]) + 4) e_len = 1;
          else if (ref_crc(q, int'(q[1]) + 2) != {q[n-2], q[n-1]}) e_crc = 1;
          else if (q[1] >= 1 && q[2][7]) begin
            if (q[1] >= 2 && q[3] == ~q[2]) begin
              e_fv = 1; e_cmdv = 1; e_cmd = q[2];
            end else e_cmp = 1;
          end else e_fv = 1;
        end
        m_act = 0;
      end else if (byte_valid_i && m_act) q.push_back(byte_i);
    end
  end

  always @(negedge clk) begin
    chk("R2 frame_valid_o", int'(frame_valid_o), int'(e_fv));
    chk("R3 crc_err_o", int'(crc_err_o), int'(e_crc));
    chk("R4 len_err_o", int'(len_err_o), int'(e_len));
    chk("R5 cmp_err_o", int'(cmp_err_o), int'(e_cmp));
    chk("R6 cmd_valid_o", int'(cmd_valid_o), int'(e_cmdv));
    if (e_cmdv) chk("R6 cmd_o", int'(cmd_o), int'(e_cmd));
    chk("R8 drv_dis_o", int'(drv_dis_o), int'(m_dis));
    seen_fv  += int'(frame_valid_o);
    seen_crc += int'(crc_err_o);
    seen_len += int'(len_err_o);
    seen_cmp += int'(cmp_err_o);
    seen_cmd += int'(cmd_valid_o);
  end

  // stimulus
  logic [7:0] fb[0:31];
  int fn = 0;

  task automatic clr_seen();
    seen_fv = 0; seen_crc = 0; seen_len = 0; seen_cmp = 0; seen_cmd = 0;
  endtask
  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic pulse_start();
    start_i = 1; @(negedge clk); start_i = 0;
  endtask
  task automatic pulse_stop();
    stop_i = 1; @(negedge clk); stop_i = 0;
  endtask
  task automatic send_byte(logic [7:0] b);
    byte_valid_i = 1; byte_i = b; @(negedge clk); byte_valid_i = 0;
  endtask
  task automatic fb_begin(logic [7:0] a, logic [7:0] c);
    fb[0] = a; fb[1] = c; fn = 2;
  endtask
  task automatic fb_add(logic [7:0] b);
    fb[fn] = b; fn++;
  endtask
  task automatic fb_crc(logic [15:0] flip);
    logic [7:0] t[$];
    logic [15:0] c;
    for (int i = 0; i < fn; i++) t.push_back(fb[i]);
    c = ref_crc(t, fn) ^ flip;
    fb_add(c[15:8]); fb_add(c[7:0]);
  endtask
  task automatic send_frame(int n);
    pulse_start();
    for (int i = 0; i < n; i++) send_byte(fb[i]);
    pulse_stop();
    idle(3);
  endtask
  task automatic cmd_frame(logic [7:0] op, logic [7:0] op2);
    fb_begin(8'h42, 8'd2); fb_add(op); fb_add(op2); fb_crc(16'h0);
  endtask

  initial begin
    idle(2);
    // R1
    chk("R1 drv_dis_o reset", int'(drv_dis_o), 0);
    chk("R1 flags reset", int'({frame_valid_o, crc_err_o, len_err_o, cmp_err_o, cmd_valid_o}), 0);
    rst_ni = 1;
    idle(3);

    // R2 normal and empty payload
    clr_seen();
    fb_begin(8'hA0, 8'd3); fb_add(8'h11); fb_add(8'h22); fb_add(8'h33); fb_crc(16'h0);
    send_frame(fn);
    fb_begin(8'h51, 8'd0); fb_crc(16'h0);
    send_frame(fn);
    chk("R2 good frames seen", seen_fv, 2);
    chk("R6 no cmd on plain frames", seen_cmd, 0);

    // R3
    clr_seen();
    fb_begin(8'hA0, 8'd2); fb_add(8'h01); fb_add(8'h02); fb_crc(16'h0001);
    send_frame(fn);
    chk("R3 crc error seen", seen_crc, 1);
    chk("R3 no frame_valid", seen_fv, 0);

    // R4 short, long, address only
    clr_seen();
    fb_begin(8'hA0, 8'd3); fb_add(8'h11); fb_add(8'h22); fb_add(8'h33); fb_crc(16'h0);
    send_frame(fn - 1);
    fb_add(8'h77);
    send_frame(fn);
    send_frame(1);
    chk("R4 length errors seen", seen_len, 3);
    chk("R4 no crc error", seen_crc, 0);

    // R5 complement mismatch and count one
    clr_seen();
    cmd_frame(8'h83, 8'h7D);
    send_frame(fn);
    fb_begin(8'h42, 8'd1); fb_add(8'h90); fb_crc(16'h0);
    send_frame(fn);
    chk("R5 complement errors seen", seen_cmp, 2);
    chk("R5 no command", seen_cmd, 0);

    // R6 good command, also with trailing payload
    clr_seen();
    cmd_frame(8'h83, 8'h7C);
    send_frame(fn);
    fb_begin(8'h42, 8'd3); fb_add(8'hC1); fb_add(8'h3E); fb_add(8'h99); fb_crc(16'h0);
    send_frame(fn);
    chk("R6 commands seen", seen_cmd, 2);

    // R7 stray traffic, restart mid-frame
    clr_seen();
    send_byte(8'h12); send_byte(8'h34);
    pulse_stop();
    idle(2);
    chk("R7 stray stop silent", seen_fv + seen_len + seen_crc + seen_cmp, 0);
    pulse_start(); send_byte(8'hEE); send_byte(8'h09);
    fb_begin(8'hA2, 8'd1); fb_add(8'h05); fb_crc(16'h0);
    send_frame(fn);
    chk("R7 restarted frame valid", seen_fv, 1);
    chk("R7 restart no length error", seen_len, 0);

    // R8 just short of the limit, then reaching it
    scl_i = 0; idle(LIMIT - 1); scl_i = 1; idle(2);
    chk("R8 below limit", int'(drv_dis_o), 0);
    scl_i = 0; idle(LIMIT - 1);
    chk("R8 one sample short", int'(drv_dis_o), 0);
    idle(1);
    chk("R8 expired", int'(drv_dis_o), 1);
    scl_i = 1; idle(2 * LIMIT);

    // R9 sticky, other command ignored, re-enable clears
    chk("R9 sticky after scl high", int'(drv_dis_o), 1);
    cmd_frame(8'h83, 8'h7C);
    send_frame(fn);
    chk("R9 other command keeps disable", int'(drv_dis_o), 1);
    cmd_frame(8'hA5, 8'h5A);
    send_frame(fn);
    chk("R9 re-enable cleared", int'(drv_dis_o), 0);

    // R10 re-enable while clock held low
    scl_i = 0; idle(LIMIT + 2);
    chk("R10 disabled again", int'(drv_dis_o), 1);
    clr_seen();
    send_frame(fn);
    chk("R10 command decoded while disabled", seen_cmd, 1);
    chk("R10 expiry wins", int'(drv_dis_o), 1);
    scl_i = 1; idle(2);
    send_frame(fn);
    chk("R10 later re-enable clears", int'(drv_dis_o), 0);

    idle(4);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule